// File: doc/BRIEF.md
# Start/stop framed word serializer

This block turns a stream of 18-bit parallel words into a single serial bit stream. Each word is captured once per word period and wrapped in a framing pair: a leading marker bit of value 1 and a trailing marker bit of value 0. The resulting 20-bit frame is sent one bit per cycle, beginning with the marker, then the payload from bit 0 upward, then the closing marker. The fixed 1-then-0 pair keeps the line toggling and gives a receiver a reliable word boundary.

The design runs on a single bit-rate clock. An internal slot counter raises `word_take` for one cycle in every 20. The word on `data_in` during that cycle is the one that is framed next, so frames follow each other with no idle slot. A second output, `emph_out`, marks every bit that starts a new run of equal values, so a line driver can use a larger swing for that bit. It is active only while `pre_en` is high. `ser_oe` stays low through reset and rises with the first framed bit.

Top module: `sfw_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `ser_out`=0, `ser_oe`=0 and `emph_out`=0.
- R2: `word_take` is high for exactly one cycle in every 20. It is high in the first cycle after reset is released, and then in every 20th cycle after that.
- R3: In the cycle after a `word_take` cycle, `ser_out` carries the opening marker, value 1.
- R4: In the next 18 cycles after the marker, `ser_out` carries `data_in[0]` through `data_in[17]` in that order, taken from the `word_take` cycle.
- R5: The 20th bit of a frame is the closing marker, value 0. It is on the line during the next `word_take` cycle.
- R6: Values on `data_in` outside a `word_take` cycle do not affect the serial stream.
- R7: Frames are sent back to back with no gap. `ser_oe` is high from the first framed bit until the next reset.
- R8: With `pre_en` high at the edge that launches a bit, `emph_out` is 1 exactly when that bit differs from the bit before it. This holds across frame boundaries. The first bit after reset is compared against 0.
- R9: With `pre_en` low at the launching edge, `emph_out` is 0 for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_en | input | 1 | Enables run-start marking on `emph_out` |
| data_in | input | 18 | Parallel payload word, sampled while `word_take` is high |
| word_take | output | 1 | High in the cycle whose `data_in` is framed next |
| ser_out | output | 1 | Serial line bit |
| ser_oe | output | 1 | Line driver enable, low from reset until the first frame |
| emph_out | output | 1 | High on the first bit of each run of equal bits |

## Verification
The hardest case to reach is a run-start decision that has to look back across a frame boundary or across a reset. Examples are the opening marker that follows a closing marker, and the first marker after reset, which is compared against the reset value 0. The stimulus covers these with directed all-zero, all-one and alternating payloads, with `pre_en` toggled between words. It also asserts reset in the middle of a frame and restarts. Between captures, `data_in` is loaded with random values to show those values are ignored.

// File: rtl/sfw_pkg.sv
// Shared constants for the framed word serializer.
// Assumes: framing values are fixed by the line protocol, not by parameters.
package sfw_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } line_lvl_e;

    localparam line_lvl_e OPEN_LVL  = LVL_HIGH;  // marker ahead of the payload
    localparam line_lvl_e CLOSE_LVL = LVL_LOW;   // marker after the payload
    localparam int        MARK_BITS = 2;         // framing bits added per word
endpackage

// File: rtl/sfw_slot_timer.sv
// Slot counter: marks the word-capture cycle once every SLOTS cycles.
// Assumes: SLOTS >= 2; the counter restarts at slot 0 on reset.
module sfw_slot_timer #(
    parameter int SLOTS = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic take
);
    localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    logic [CW-1:0] slot_q;

    // Advance the slot index and wrap after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)             slot_q <= '0;
        else if (slot_q == LAST) slot_q <= '0;
        else                    slot_q <= slot_q + 1'b1;
    end

    assign take = (slot_q == '0);
endmodule

// File: rtl/sfw_frame_shifter.sv
// Builds the marker-wrapped frame and shifts it out LSB first.
// Assumes: load arrives exactly once per frame length, so the remainder
// register is empty when the next frame loads.
module sfw_frame_shifter
    import sfw_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              nxt_bit,
    output logic              ser_q,
    output logic              oe_q
);
    localparam int FRAME_W = DATA_W + MARK_BITS;

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-2:0] rest_q;

    assign frame   = {CLOSE_LVL, data, OPEN_LVL};
    assign nxt_bit = load ? frame[0] : rest_q[0];

    // Hold the frame bits still to be sent.
    always_ff @(posedge clk) begin
        if (!rst_n)    rest_q <= '0;
        else if (load) rest_q <= frame[FRAME_W-1:1];
        else           rest_q <= {1'b0, rest_q[FRAME_W-2:1]};
    end

    // Register the line bit and the sticky driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            ser_q <= nxt_bit;
            oe_q  <= oe_q | load;
        end
    end
endmodule

// File: rtl/sfw_emph_marker.sv
// Flags the first bit of each run of equal line bits.
// Assumes: cur_bit is the bit on the line now, and nxt_bit is the bit
// launched at the coming edge.
module sfw_emph_marker (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic nxt_bit,
    input  logic cur_bit,
    output logic emph_q
);
    // Mark a bit when it breaks the run of the bit before it.
    always_ff @(posedge clk) begin
        if (!rst_n) emph_q <= 1'b0;
        else        emph_q <= enable & (nxt_bit ^ cur_bit);
    end
endmodule

// File: rtl/sfw_serializer.sv
// Top level: framed word serializer with run-start marking.
// Assumes: one clock at the bit rate; the upstream source drives data_in
// in the word_take cycle.
module sfw_serializer
    import sfw_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_en,
    input  logic [DATA_W-1:0] data_in,
    output logic              word_take,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              emph_out
);
    localparam int SLOTS = DATA_W + MARK_BITS;

    logic nxt_bit;

    sfw_slot_timer #(.SLOTS(SLOTS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (word_take)
    );

    sfw_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (word_take),
        .data    (data_in),
        .nxt_bit (nxt_bit),
        .ser_q   (ser_out),
        .oe_q    (ser_oe)
    );

    sfw_emph_marker u_emph (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (pre_en),
        .nxt_bit (nxt_bit),
        .cur_bit (ser_out),
        .emph_q  (emph_out)
    );
endmodule

// File: rtl/sfw_serializer_chk.sv
// Property checker for the serializer ports; attached by bind below.
module sfw_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic pre_en,
    input logic word_take,
    input logic ser_out,
    input logic ser_oe,
    input logic emph_out
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && !ser_oe && !emph_out));

    p_take_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_take |=> !word_take);

    p_open_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_take |=> ser_out);

    p_close_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_take && ser_oe) |-> !ser_out);

    p_oe_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |=> ser_oe);

    p_run_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> (emph_out == (ser_out != $past(ser_out))));

    p_emph_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_en |=> !emph_out);
endmodule

bind sfw_serializer sfw_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_en    (pre_en),
    .word_take (word_take),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe),
    .emph_out  (emph_out)
);

// File: tb/sfw_serializer_tb.sv
// Bench: directed and seeded random words checked bit by bit.
module sfw_serializer_tb_top;
    localparam int DW = 18;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pre_en = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          word_take, ser_out, ser_oe, emph_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit prev_bit = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sfw_serializer #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .data_in(data_in),
        .word_take(word_take), .ser_out(ser_out), .ser_oe(ser_oe),
        .emph_out(emph_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected frame bit k: opening 1, payload LSB first, closing 0.
    function automatic bit frame_bit(input logic [DW-1:0] d, input int k);
        if (k == 0)      return 1'b1;
        if (k == FW - 1) return 1'b0;
        return d[k-1];
    endfunction

    // Called at a negedge where word_take should be high.
    task automatic send_word(input logic [DW-1:0] d, input bit pe, input bit noise);
        check(word_take === 1'b1, "R2 take at capture", int'(word_take), 1);
        data_in = d;
        pre_en  = pe;
        for (int k = 0; k < FW; k++) begin
            bit b;
            @(negedge clk);
            b = frame_bit(d, k);
            if (k == 0)           check(ser_out === b, "R3 open marker", int'(ser_out), int'(b));
            else if (k == FW - 1) check(ser_out === b, "R5 close marker", int'(ser_out), int'(b));
            else                  check(ser_out === b, noise ? "R4/R6 payload bit" : "R4 payload bit",
                                        int'(ser_out), int'(b));
            if (pe) check(emph_out === (b != prev_bit), "R8 run start", int'(emph_out), int'(b != prev_bit));
            else    check(emph_out === 1'b0, "R9 marking off", int'(emph_out), 0);
            check(ser_oe === 1'b1, "R7 driver enable", int'(ser_oe), 1);
            check(word_take === (k == FW - 1), "R2 take spacing", int'(word_take), int'(k == FW - 1));
            prev_bit = b;
            if (noise && k < FW - 1) data_in = DW'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'd20517));
        pre_en  = 1'b1;
        data_in = 18'h3FFFF;
        repeat (3) @(negedge clk);
        check(ser_out === 1'b0, "R1 reset line", int'(ser_out), 0);
        check(ser_oe === 1'b0, "R1 reset enable", int'(ser_oe), 0);
        check(emph_out === 1'b0, "R1 reset marking", int'(emph_out), 0);
        rst_n = 1'b1;
        prev_bit = 1'b0;

        // Directed corner payloads.
        send_word(18'h00000, 1'b1, 1'b0);
        send_word(18'h3FFFF, 1'b1, 1'b0);
        send_word(18'h2AAAA, 1'b1, 1'b1);
        send_word(18'h15555, 1'b0, 1'b1);
        send_word(18'h3FFFF, 1'b0, 1'b0);
        send_word(18'h00001, 1'b1, 1'b1);
        send_word(18'h20000, 1'b1, 1'b1);

        // Seeded random words with marking mixed.
        for (int i = 0; i < 60; i++)
            send_word(DW'($urandom), 1'($urandom), 1'($urandom));

        // Reset in the middle of a frame, then restart.
        data_in = 18'h0F0F0;
        pre_en  = 1'b1;
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(ser_out === 1'b0, "R1 mid-frame reset line", int'(ser_out), 0);
        check(ser_oe === 1'b0, "R1 mid-frame reset enable", int'(ser_oe), 0);
        check(emph_out === 1'b0, "R1 mid-frame reset marking", int'(emph_out), 0);
        rst_n = 1'b1;
        prev_bit = 1'b0;
        send_word(18'h3FFFF, 1'b1, 1'b1);
        send_word(18'h00000, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc >= 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule